// File: doc/BRIEF.md
# Clock Source and Prescaler Controller

This block turns a software command word into the clock settings that actually take effect. The command word asks for a system oscillator, a low-frequency oscillator and two prescale codes, one for the system clock and one for the timer tick. The block answers with a separate status word that shows what is in force at the moment. A source change is not immediate. The block waits for the target oscillator to report ready, and only then switches the status bit. Prescale requests are clamped so that no rate can be faster than the active system source allows.

From a free-running 8-bit counter clocked by the 32 MHz reference, the block derives two one-cycle enable strobes: one at the effective system-clock rate and one at the effective tick rate. Downstream logic uses these strobes as clock enables. All pins are plain control and status signals. The command port is a single-cycle write strobe with no back-pressure, and a later write replaces an earlier one.

Top module: `clkctl_top`

## Requirements
- R1: After reset the status word reads 0xC9, busy is low, and the held command equals 0xC9.
- R2: Command and status share one layout. Bit 7 selects the low-frequency source (1 = RC, 0 = crystal). Bit 6 selects the system source (1 = 16 MHz RC, 0 = 32 MHz crystal). Bits 5:3 hold the tick prescale code. Bits 2:0 hold the clock prescale code. A code c means the 32 MHz reference divided by 2^c.
- R3: While command bit 6 differs from status bit 6, status bit 6 holds until the target's ready input is high: `hf_rc_rdy` when moving to the RC, `hf_xtal_rdy` when moving to the crystal. Status bit 6 takes the requested value at the clock edge where that ready input is sampled high.
- R4: While status bit 6 is 1 and command bit 7 differs from status bit 7, status bit 7 takes the requested value at the edge where the target's ready input is sampled high: `lf_rc_rdy` for the RC, `lf_xtal_rdy` for the crystal.
- R5: While status bit 6 is 0, status bit 7 never changes. A differing low-frequency request stays pending and is applied under R4 once the RC runs the system.
- R6: Each status prescale field equals the commanded code, except that a commanded 000 reads 001 whenever the system source is the RC. The fields update one edge after the write, and they are recomputed at the edge where status bit 6 switches.
- R7: `busy` is high exactly when status bit 6 or bit 7 differs from the held command.
- R8: A strobe whose effective code is 000 is high on every cycle.
- R9: For an effective code c > 0, a strobe is high exactly when the low c bits of the free-running counter are all ones. The counter is 0 after reset and increments on every cycle, so the strobe is a one-cycle pulse every 2^c cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command word (layout per R2) |
| hf_xtal_rdy | input | 1 | 32 MHz crystal ready |
| hf_rc_rdy | input | 1 | 16 MHz RC ready |
| lf_xtal_rdy | input | 1 | 32 kHz crystal ready |
| lf_rc_rdy | input | 1 | 32 kHz RC ready |
| status | output | 8 | Settings in effect (layout per R2) |
| busy | output | 1 | A source change is pending |
| sys_stb | output | 1 | System-clock enable strobe |
| tick_stb | output | 1 | Timer-tick enable strobe |

## Verification
Some properties are checked by assertions on every cycle. A source bit never moves without its ready input or its permission. The low-frequency bit is frozen while the crystal runs the system. The clock field never reads 000 under the RC. A code-000 strobe is always high, and a divided strobe never stays high for two cycles in a row. Other behaviour only shows up in the bench's scenarios: the exact edge at which a pending low-frequency request lands after the system returns to the RC, the pulse phase against the counter, and the way busy tracks overlapping writes. The bench reaches these scenarios through random writes and ready patterns, which it compares cycle by cycle against a model of the requirements.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int CODE_W = 3;
  localparam int WORD_W = 8;
  localparam logic [WORD_W-1:0] RST_WORD = 8'hC9;

  typedef struct packed {
    logic              lf_rc;
    logic              sys_rc;
    logic [CODE_W-1:0] tick;
    logic [CODE_W-1:0] clk;
  } ctl_word_t;

  // RC system source cannot deliver the undivided reference rate
  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c,
                                                   input logic sys_rc);
    if (sys_rc && c == '0) return CODE_W'(1);
    return c;
  endfunction
endpackage

// File: rtl/clkctl_src_sw.sv
module clkctl_src_sw #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic allow,
  input  logic rdy_to1,
  input  logic rdy_to0,
  output logic cur,
  output logic nxt
);
  logic tgt_rdy;
  assign tgt_rdy = req ? rdy_to1 : rdy_to0;

  always_comb begin
    nxt = cur;
    if (allow && (req != cur) && tgt_rdy) nxt = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= RST_VAL;
    else        cur <= nxt;
  end

  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rdy |=> $stable(cur)); // R3

  AST_NO_PERMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> $stable(cur)); // R5
endmodule

// File: rtl/clkctl_strobe_gen.sv
module clkctl_strobe_gen #(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 3,
  parameter int N_OUT  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_OUT-1:0][CODE_W-1:0]   code,
  output logic [N_OUT-1:0]               stb
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [CNT_W-1:0] mask;
    assign mask   = ~({CNT_W{1'b1}} << code[g]);
    assign stb[g] = (cnt & mask) == mask;

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (code[g] == '0) |-> stb[g]); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (stb[g] && code[g] != '0) |=> (!stb[g] || code[g] != $past(code[g]))); // R9
  end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  input  logic       hf_xtal_rdy,
  input  logic       hf_rc_rdy,
  input  logic       lf_xtal_rdy,
  input  logic       lf_rc_rdy,
  output logic [7:0] status,
  output logic       busy,
  output logic       sys_stb,
  output logic       tick_stb
);
  ctl_word_t cmd_q, stat;
  logic sys_cur, sys_nxt, lf_cur, lf_nxt;
  logic [CODE_W-1:0] tick_q, clk_q;
  logic [1:0][CODE_W-1:0] codes;
  logic [1:0] stbs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= ctl_word_t'(RST_WORD);
    else if (cmd_we) cmd_q <= ctl_word_t'(cmd_wdata);
  end

  clkctl_src_sw #(.RST_VAL(1'b1)) u_sys_sw (
    .clk(clk), .rst_n(rst_n), .req(cmd_q.sys_rc), .allow(1'b1),
    .rdy_to1(hf_rc_rdy), .rdy_to0(hf_xtal_rdy), .cur(sys_cur), .nxt(sys_nxt));

  // low-frequency source may only move while the RC runs the system
  clkctl_src_sw #(.RST_VAL(1'b1)) u_lf_sw (
    .clk(clk), .rst_n(rst_n), .req(cmd_q.lf_rc), .allow(sys_cur),
    .rdy_to1(lf_rc_rdy), .rdy_to0(lf_xtal_rdy), .cur(lf_cur), .nxt(lf_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= RST_WORD[5:3];
      clk_q  <= RST_WORD[2:0];
    end else begin
      tick_q <= clamp_code(cmd_q.tick, sys_nxt);
      clk_q  <= clamp_code(cmd_q.clk,  sys_nxt);
    end
  end

  assign stat   = '{lf_rc: lf_cur, sys_rc: sys_cur, tick: tick_q, clk: clk_q};
  assign status = stat;
  assign busy   = (cmd_q.sys_rc != sys_cur) || (cmd_q.lf_rc != lf_cur);

  assign codes = {tick_q, clk_q};

  clkctl_strobe_gen #(.CNT_W(CNT_W), .CODE_W(CODE_W), .N_OUT(2)) u_stb (
    .clk(clk), .rst_n(rst_n), .code(codes), .stb(stbs));

  assign sys_stb  = stbs[0];
  assign tick_stb = stbs[1];

  AST_CLAMP_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    sys_cur |-> (clk_q != '0)); // R6

  AST_CLAMP_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sys_cur |-> (tick_q != '0)); // R6

  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_we) |=> !busy); // R7
endmodule

// File: tb/tb_clkctl_top.sv
module tb_clkctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic hf_xtal_rdy = 1'b0, hf_rc_rdy = 1'b0, lf_xtal_rdy = 1'b0, lf_rc_rdy = 1'b0;
  logic [7:0] status;
  logic busy, sys_stb, tick_stb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkctl_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .hf_xtal_rdy(hf_xtal_rdy), .hf_rc_rdy(hf_rc_rdy),
    .lf_xtal_rdy(lf_xtal_rdy), .lf_rc_rdy(lf_rc_rdy),
    .status(status), .busy(busy), .sys_stb(sys_stb), .tick_stb(tick_stb));

  // model state built from the requirements
  logic [7:0] mc, ms;
  logic [7:0] mcnt;

  function automatic logic [2:0] fclamp(input logic [2:0] c, input logic rc);
    return (rc && c == 3'd0) ? 3'd1 : c;
  endfunction

  function automatic logic fstb(input logic [2:0] c, input logic [7:0] cnt);
    logic [7:0] m;
    m = 8'((16'd1 << c) - 16'd1);
    return (cnt & m) == m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = 8'hC9; ms = 8'hC9; mcnt = '0;
    end else begin
      logic nsys, nlf, rdy_s, rdy_l;
      rdy_s = mc[6] ? hf_rc_rdy : hf_xtal_rdy;
      rdy_l = mc[7] ? lf_rc_rdy : lf_xtal_rdy;
      nsys = (mc[6] != ms[6] && rdy_s) ? mc[6] : ms[6];
      nlf  = (ms[6] && mc[7] != ms[7] && rdy_l) ? mc[7] : ms[7];
      ms = {nlf, nsys, fclamp(mc[5:3], nsys), fclamp(mc[2:0], nsys)};
      if (cmd_we) mc = cmd_wdata;
      mcnt = mcnt + 8'd1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(status[6] == ms[6], "R3 system source", status[6], ms[6]);
    chk(status[7] == ms[7], ms[6] ? "R4 low-freq source" : "R5 low-freq held",
        status[7], ms[7]);
    chk(status[2:0] == ms[2:0], "R6 clock code", status[2:0], ms[2:0]);
    chk(status[5:3] == ms[5:3], "R2 tick code", status[5:3], ms[5:3]);
    chk(busy == ((mc[7:6]) != (ms[7:6])), "R7 busy", busy, (mc[7:6] != ms[7:6]));
    chk(sys_stb == fstb(ms[2:0], mcnt), (ms[2:0] == 0) ? "R8 sys strobe" : "R9 sys strobe",
        sys_stb, fstb(ms[2:0], mcnt));
    chk(tick_stb == fstb(ms[5:3], mcnt), (ms[5:3] == 0) ? "R8 tick strobe" : "R9 tick strobe",
        tick_stb, fstb(ms[5:3], mcnt));
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic [3:0] rdy);
    @(negedge clk);
    check_all();
    cmd_we = we; cmd_wdata = wd;
    {hf_xtal_rdy, hf_rc_rdy, lf_xtal_rdy, lf_rc_rdy} = rdy;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'hC9, "R1 reset status", status, 8'hC9);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    // directed: request crystal with codes 000, ready withheld, then given
    step(1'b1, 8'h80, 4'b0000);
    repeat (6) step(1'b0, 8'h00, 4'b0000);
    step(1'b0, 8'h00, 4'b1000);
    repeat (300) step(1'b0, 8'h00, 4'b0000);
    // directed: low-frequency to crystal while system on crystal stays pending (R5)
    step(1'b1, 8'h00, 4'b0011);
    repeat (10) step(1'b0, 8'h00, 4'b0011);
    // back to RC system: pending low-frequency change lands after (R4)
    step(1'b1, 8'h40, 4'b0100);
    repeat (3) step(1'b0, 8'h00, 4'b0000);
    step(1'b0, 8'h00, 4'b0010);
    repeat (300) step(1'b0, 8'h00, 4'b0000);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic we;
      logic [3:0] r;
      we = ($urandom % 8) == 0;
      r  = 4'($urandom) & 4'($urandom);
      step(we, 8'($urandom), r);
    end
    step(1'b0, 8'h00, 4'b0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule